// File: doc/BRIEF.md
# Bank-Interleaved Access Sequencer

This block paces accesses to a multi-bank dynamic memory and lets an access to another bank overlap the one in flight. Each access runs a row phase, a column phase whose length is a programmed count of clock cycles (the column-address hold window), and a held phase that lasts while the access request stays high. With overlap enabled, the address select drops back to the row address once the hold window has passed. A strobe to a different bank may then queue the next access, and that access starts on the same edge at which the request falls.

Two strobe conventions are supported. In latch-enable style the strobe is a pulse qualified by chip select, and an overlapped start needs the request to have been high for at least one earlier clock. In address-strobe style the strobe is a level, and an overlapped start needs the strobe to have been low for a minimum number of clock edges. A start that breaks these rules is dropped and flagged for one cycle. A back-to-back access to the same bank, or any access after a refresh, waits out a programmed precharge count. The block also drives a data acknowledge and a wait-state request.

Top module: `ileave_seq`

## Requirements
- R1: While reset is held low, all of `ras`, `cas`, `col_sel`, `ack`, `wait_o` and `proto_err` are 0.
- R2: A start is a clock edge at which `strobe` and `cs` are high and `strobe` was low at the previous edge. A start accepted at edge k while idle, with no precharge owed, raises `ras[b]` from edge k+1, where b is the `bank` value at edge k. At most one `ras` bit is high at a time.
- R3: `cas` rises one edge after the access's `ras` bit. `col_sel` is 1 for the first max(1,`cfg_hold`) cycles of `cas`. After that it is 0 for the rest of the access when `cfg_pipe_en`=1, and stays 1 until the access ends when `cfg_pipe_en`=0.
- R4: An access ends at the first edge in its held phase at which `areq` is low. `ras` and `cas` are 0 after that edge unless an overlapped access launches.
- R5: Let E be the edge at which an access to bank b ends. The next access to bank b raises `ras` at edge max(E+`cfg_pre`+1, k+1), where k is its start edge.
- R6: With no refresh since the last launch, an access to a different bank that was queued during the held phase launches at edge E itself. One that starts at k>E launches at k+1, whatever precharge is still owed.
- R7: No access launches while `refresh` is high. After the last edge G with `refresh` high, the next launch is at edge G+`cfg_pre`+1 or later, for any bank.
- R8: With `cfg_pipe_en`=1, a start is accepted while an access is in flight only during its held phase and, when `cfg_mode`=0, only if `areq` is high at that edge and at the previous edge. Any other start is ignored: nothing launches from it, and `proto_err` is 1 for the following cycle.
- R9: When `cfg_mode`=1, an overlapped start also needs `strobe` to have been low at `MIN_NEG` (default 2) consecutive edges before it. Otherwise the start is ignored and `proto_err` pulses.
- R10: With `cfg_pipe_en`=0, a start while an access is active, or while one is already queued, is ignored and `proto_err` pulses.
- R11: `ack` equals `cfg_ack_en` AND `cas` AND `areq` in the same cycle.
- R12: With `cfg_wait_en`=1, `wait_o` is 1 in the cycle of an accepted start, while the access is queued, and during its row phase. It is 0 once `cas` is high.
- R13: `burst_allow` is 1 exactly when `cfg_pipe_en` is 0, because sequential column bursts cannot be combined with overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pipe_en | input | 1 | Enable overlapped bank accesses |
| cfg_mode | input | 1 | 0: latch-enable strobe style, 1: address-strobe style |
| cfg_wait_en | input | 1 | Enable the wait-state request |
| cfg_ack_en | input | 1 | Enable the data acknowledge |
| cfg_hold | input | CW | Column-address hold length in cycles |
| cfg_pre | input | CW | Precharge length in cycles |
| strobe | input | 1 | Access start strobe |
| cs | input | 1 | Chip select |
| areq | input | 1 | Access request, keeps the current access alive |
| bank | input | BW | Bank number of the starting access |
| refresh | input | 1 | Refresh in progress |
| ras | output | BANKS | Row strobe, one bit per bank |
| cas | output | 1 | Column strobe |
| col_sel | output | 1 | Address mux select: 1 column, 0 row |
| ack | output | 1 | Data acknowledge |
| wait_o | output | 1 | Wait-state request |
| proto_err | output | 1 | One-cycle pulse on an ignored start |
| burst_allow | output | 1 | Column burst modes allowed |

## Verification
A wrong phase state appears at the ports within one edge, because `cas`, `col_sel` and `wait_o` are decoded from it: a column phase that is too long or too short shifts the fall of `col_sel` by a cycle. A stale queued access or a precharge counter that is off shows up only at the next launch, as a `ras` bit rising on the wrong edge or for the wrong bank. The bench therefore queues the expected bank and launch edge for every access and compares each `ras` rise against them. A dropped or wrongly accepted start is visible one cycle later through `proto_err` and through a launch that is extra or missing.

// File: rtl/ileave_pkg.sv
`timescale 1ns/1ps
package ileave_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COLH = 2'd2,
    ST_HELD = 2'd3
  } acc_st_e;

  // Column hold ends when the remaining count reaches one (a zero count acts as one).
  function automatic logic hold_last(input int unsigned remaining);
    return remaining <= 1;
  endfunction

  // Saturating increment used by the strobe low-time counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v < lim) ? v + 1 : lim;
  endfunction
endpackage

// File: rtl/ileave_strobe.sv
`timescale 1ns/1ps
module ileave_strobe #(
  parameter int MIN_NEG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic cs,
  input  logic areq,
  input  logic mode_ads,
  output logic start_ev,
  output logic rule_ok
);
  import ileave_pkg::*;
  localparam int NW = $clog2(MIN_NEG + 1);

  logic          strobe_q;
  logic          areq_q;
  logic [NW-1:0] neg_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      areq_q   <= 1'b0;
      neg_cnt  <= NW'(MIN_NEG);
    end else begin
      strobe_q <= strobe;
      areq_q   <= areq;
      if (strobe) neg_cnt <= '0;
      else        neg_cnt <= NW'(sat_inc(int'(neg_cnt), MIN_NEG));
    end
  end

  assign start_ev = strobe & ~strobe_q & cs;
  // Overlap rule per strobe style.
  assign rule_ok  = mode_ads ? (areq & (neg_cnt >= NW'(MIN_NEG)))
                             : (areq & areq_q);
endmodule

// File: rtl/ileave_prech.sv
`timescale 1ns/1ps
module ileave_prech #(
  parameter int BW = 2,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_pre,
  input  logic          refresh,
  input  logic          in_idle,
  input  logic          end_ev,
  input  logic          launch,
  input  logic [BW-1:0] launch_bank,
  output logic          pre_done,
  output logic          ref_seen,
  output logic [BW-1:0] last_bank
);
  logic [CW-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      ref_seen  <= 1'b0;
      last_bank <= '0;
    end else begin
      if (end_ev || (in_idle && refresh)) pre_cnt <= cfg_pre;
      else if (in_idle && pre_cnt != '0)  pre_cnt <= pre_cnt - 1'b1;
      if (refresh)     ref_seen <= 1'b1;
      else if (launch) ref_seen <= 1'b0;
      if (launch) last_bank <= launch_bank;
    end
  end

  assign pre_done = (pre_cnt == '0);
endmodule

// File: rtl/ileave_seq.sv
`timescale 1ns/1ps
module ileave_seq #(
  parameter int BANKS   = 4,
  parameter int CW      = 4,
  parameter int MIN_NEG = 2,
  localparam int BW     = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pipe_en,
  input  logic             cfg_mode,
  input  logic             cfg_wait_en,
  input  logic             cfg_ack_en,
  input  logic [CW-1:0]    cfg_hold,
  input  logic [CW-1:0]    cfg_pre,
  input  logic             strobe,
  input  logic             cs,
  input  logic             areq,
  input  logic [BW-1:0]    bank,
  input  logic             refresh,
  output logic [BANKS-1:0] ras,
  output logic             cas,
  output logic             col_sel,
  output logic             ack,
  output logic             wait_o,
  output logic             proto_err,
  output logic             burst_allow
);
  import ileave_pkg::*;

  acc_st_e       st;
  logic [CW-1:0] hold_cnt;
  logic          pend_v;
  logic [BW-1:0] pend_bank;

  // Named internal events.
  logic          start_ev, rule_ok;
  logic          acc_ev, rej_ev, end_now, direct_ev, idle_go, launch_ev, end_ev;
  logic          pre_done, ref_seen, bank_hit;
  logic [BW-1:0] last_bank;

  ileave_strobe #(.MIN_NEG(MIN_NEG)) u_strobe (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cs(cs), .areq(areq),
    .mode_ads(cfg_mode), .start_ev(start_ev), .rule_ok(rule_ok)
  );

  ileave_prech #(.BW(BW), .CW(CW)) u_prech (
    .clk(clk), .rst_n(rst_n), .cfg_pre(cfg_pre), .refresh(refresh),
    .in_idle(st == ST_IDLE), .end_ev(end_ev), .launch(launch_ev),
    .launch_bank(pend_bank), .pre_done(pre_done), .ref_seen(ref_seen),
    .last_bank(last_bank)
  );

  always_comb begin
    acc_ev    = start_ev & ~pend_v &
                ((st == ST_IDLE) | ((st == ST_HELD) & cfg_pipe_en & rule_ok));
    rej_ev    = start_ev & ~acc_ev;
    bank_hit  = (pend_bank == last_bank);
    end_now   = (st == ST_HELD) & ~areq;
    direct_ev = end_now & pend_v & ~bank_hit & ~ref_seen & ~refresh;
    idle_go   = (st == ST_IDLE) & pend_v & ~refresh &
                (pre_done | (~bank_hit & ~ref_seen));
    launch_ev = direct_ev | idle_go;
    end_ev    = end_now & ~direct_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hold_cnt  <= '0;
      pend_v    <= 1'b0;
      pend_bank <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= rej_ev;
      if (acc_ev) begin
        pend_v    <= 1'b1;
        pend_bank <= bank;
      end else if (launch_ev) begin
        pend_v <= 1'b0;
      end
      case (st)
        ST_IDLE: if (launch_ev) st <= ST_ROW;
        ST_ROW: begin
          st       <= ST_COLH;
          hold_cnt <= cfg_hold;
        end
        ST_COLH: begin
          if (hold_last(int'(hold_cnt))) st <= ST_HELD;
          else hold_cnt <= hold_cnt - 1'b1;
        end
        ST_HELD: if (end_now) st <= direct_ev ? ST_ROW : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < BANKS; i++) begin : g_ras
    assign ras[i] = (st != ST_IDLE) && (last_bank == BW'(i));
  end

  assign cas         = (st == ST_COLH) | (st == ST_HELD);
  assign col_sel     = (st == ST_COLH) | ((st == ST_HELD) & ~cfg_pipe_en);
  assign ack         = cfg_ack_en & cas & areq;
  assign wait_o      = cfg_wait_en & (acc_ev | pend_v | (st == ST_ROW));
  assign burst_allow = ~cfg_pipe_en;
endmodule

// File: rtl/ileave_seq_chk.sv
`timescale 1ns/1ps
module ileave_seq_chk #(
  parameter int BANKS = 4,
  parameter int CW    = 4,
  localparam int BW   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    cfg_pre,
  input logic             cfg_wait_en,
  input logic             strobe,
  input logic             cs,
  input logic             areq,
  input logic             refresh,
  input logic [BANKS-1:0] ras,
  input logic             cas,
  input logic             col_sel,
  input logic             ack,
  input logic             wait_o,
  input logic             proto_err,
  input logic             launch_ev,
  input logic             acc_ev,
  input logic             end_ev,
  input logic [BW-1:0]    pend_bank,
  input logic [BW-1:0]    last_bank
);
  logic [CW:0] gap;
  logic        seen_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap      <= '0;
      seen_end <= 1'b0;
    end else begin
      if (end_ev) seen_end <= 1'b1;
      if (ras != '0)       gap <= '0;
      else if (gap != '1)  gap <= gap + 1'b1;
    end
  end

  p_ras_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ras));
  p_cas_in_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cas |-> (ras != '0));
  p_col_on_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas) |-> col_sel);
  p_same_bank_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_ev && seen_end && ras == '0 && pend_bank == last_bank)
      |-> (gap >= {1'b0, cfg_pre}));
  p_refresh_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && ras == '0) |=> (ras == '0));
  p_err_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(strobe && cs));
  p_ack_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (areq && cas));
  p_wait_on_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && cfg_wait_en) |-> wait_o);
endmodule

bind ileave_seq ileave_seq_chk #(.BANKS(BANKS), .CW(CW)) u_chk (.*);

// File: tb/ileave_seq_tb.sv
`timescale 1ns/1ps
module ileave_seq_tb;
  localparam int BANKS = 4;
  localparam int CW    = 4;
  localparam int BW    = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_pipe_en, cfg_mode, cfg_wait_en, cfg_ack_en;
  logic [CW-1:0] cfg_hold, cfg_pre;
  logic strobe, cs, areq, refresh;
  logic [BW-1:0] bank;
  logic [BANKS-1:0] ras;
  logic cas, col_sel, ack, wait_o, proto_err, burst_allow;

  ileave_seq #(.BANKS(BANKS), .CW(CW), .MIN_NEG(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pipe_en(cfg_pipe_en), .cfg_mode(cfg_mode),
    .cfg_wait_en(cfg_wait_en), .cfg_ack_en(cfg_ack_en), .cfg_hold(cfg_hold),
    .cfg_pre(cfg_pre), .strobe(strobe), .cs(cs), .areq(areq), .bank(bank),
    .refresh(refresh), .ras(ras), .cas(cas), .col_sel(col_sel), .ack(ack),
    .wait_o(wait_o), .proto_err(proto_err), .burst_allow(burst_allow)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Scoreboard of expected launches: bank and edge index.
  typedef struct { int b; int edge_n; } exp_t;
  exp_t exp_q[$];

  task automatic expect_ras(input int b, input int edge_n);
    exp_t e;
    e.b = b;
    e.edge_n = edge_n;
    exp_q.push_back(e);
  endtask

  logic [BANKS-1:0] prev_ras = '0;
  logic [BANKS-1:0] rise;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = '0;
    end else begin
      rise = ras & ~prev_ras;
      if (rise != '0) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected row strobe", int'(rise), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R2 row strobe bank", int'(rise), 1 << e.b);
          chk("R5 R6 R7 launch edge", cyc, e.edge_n);
        end
      end
      prev_ras = ras;
    end
  end

  task automatic go(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse(input int b);
    strobe = 1'b1;
    cs     = 1'b1;
    bank   = BW'(b);
    @(negedge clk);
    strobe = 1'b0;
    cs     = 1'b0;
  endtask

  logic done = 1'b0;

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_pipe_en = 1'b0; cfg_mode = 1'b0; cfg_wait_en = 1'b1;
    cfg_ack_en = 1'b1; cfg_hold = 4'd2; cfg_pre = 4'd3;
    strobe = 1'b0; cs = 1'b0; areq = 1'b0; refresh = 1'b0; bank = '0;
    repeat (3) @(negedge clk);
    chk("R1 ras reset", int'(ras), 0);
    chk("R1 cas reset", int'(cas), 0);
    chk("R1 col_sel reset", int'(col_sel), 0);
    chk("R1 ack reset", int'(ack), 0);
    chk("R1 wait reset", int'(wait_o), 0);
    chk("R1 proto_err reset", int'(proto_err), 0);
    chk("R13 burst allowed without overlap", int'(burst_allow), 1);
    rst_n = 1'b1;

    // Serialized accesses, latch-enable style.
    go(10);
    areq = 1'b1; strobe = 1'b1; cs = 1'b1; bank = 2'd0;
    #1 chk("R12 wait in start cycle", int'(wait_o), 1);
    @(negedge clk); strobe = 1'b0; cs = 1'b0;
    expect_ras(0, 12);
    chk("R12 wait while queued", int'(wait_o), 1);
    go(12);
    chk("R3 no cas in row phase", int'(cas), 0);
    chk("R3 row address in row phase", int'(col_sel), 0);
    go(13);
    chk("R3 cas one edge after ras", int'(cas), 1);
    chk("R3 column address on cas", int'(col_sel), 1);
    chk("R11 ack with cas and areq", int'(ack), 1);
    chk("R12 wait drops at cas", int'(wait_o), 0);
    go(14);
    pulse(1);
    chk("R10 start while busy flagged", int'(proto_err), 1);
    go(16);
    chk("R3 column kept without overlap", int'(col_sel), 1);
    chk("R3 cas held", int'(cas), 1);
    chk("R10 error is a single pulse", int'(proto_err), 0);
    areq = 1'b0;
    #1 chk("R11 ack follows areq low", int'(ack), 0);
    go(17);
    chk("R4 ras off after end", int'(ras), 0);
    chk("R4 cas off after end", int'(cas), 0);
    areq = 1'b1;
    pulse(0);
    expect_ras(0, 21);
    go(24); areq = 1'b0;
    go(25); areq = 1'b1;
    pulse(2);
    expect_ras(2, 27);
    go(30); areq = 1'b0;

    // Overlapped accesses, latch-enable style.
    go(40);
    cfg_pipe_en = 1'b1;
    #1 chk("R13 burst blocked with overlap", int'(burst_allow), 0);
    areq = 1'b1;
    pulse(1);
    expect_ras(1, 42);
    go(45);
    chk("R3 cas still high in held phase", int'(cas), 1);
    chk("R3 row address back after hold", int'(col_sel), 0);
    pulse(3);
    chk("R8 overlapped start accepted", int'(proto_err), 0);
    chk("R12 wait for queued access", int'(wait_o), 1);
    areq = 1'b0;
    expect_ras(3, 47);
    go(47); areq = 1'b1;
    go(48);
    pulse(0);
    chk("R8 start before hold met flagged", int'(proto_err), 1);
    go(51);
    areq = 1'b0;
    pulse(0);
    chk("R8 start without areq flagged", int'(proto_err), 1);
    chk("R4 access ended", int'(ras), 0);
    go(60);
    chk("R8 ignored start launches nothing", int'(ras), 0);

    // Address-strobe style.
    cfg_mode = 1'b1; cs = 1'b1; areq = 1'b1; strobe = 1'b1; bank = 2'd2;
    expect_ras(2, 62);
    go(64); strobe = 1'b0;
    go(65); strobe = 1'b1; bank = 2'd0;
    go(66);
    chk("R9 short negation flagged", int'(proto_err), 1);
    strobe = 1'b0;
    go(68); strobe = 1'b1;
    go(69);
    chk("R9 full negation accepted", int'(proto_err), 0);
    strobe = 1'b0; areq = 1'b0;
    expect_ras(0, 70);
    go(70); areq = 1'b1;
    go(73); areq = 1'b0;

    // Refresh between accesses forces precharge even for another bank.
    go(74);
    cfg_mode = 1'b0; cs = 1'b0; refresh = 1'b1;
    go(75);
    areq = 1'b1;
    pulse(1);
    expect_ras(1, 82);
    go(78); refresh = 1'b0;
    go(79);
    chk("R7 no launch right after refresh", int'(ras), 0);
    go(81);
    chk("R7 precharge after refresh", int'(ras), 0);
    go(85); areq = 1'b0;
    go(95);
    chk("R2 every expected launch seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule